// File: doc/BRIEF.md
# PCIe MSI Interrupt Capture Controller

This block sits on the root-complex side of a PCIe link. It turns inbound message-signalled-interrupt memory writes into per-vector pending bits, and it drives one level interrupt toward the host CPU. Software programs a 64-bit doorbell address through a 32-bit register interface. Vectors are banked in groups of 32. Each group has its own enable, mask and pending registers.

When an inbound write carries exactly the programmed address, its data word selects a vector. That vector's pending bit is latched, provided the vector exists and is enabled. The host reads a group's pending register, services the vectors in it, and clears them one bit at a time. The interrupt line stays high while any pending bit is unmasked.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset every implemented register reads zero and `irq_out` is low.
- R2: The doorbell address low word at offset 0x820 and high word at 0x824 read back exactly what was written.
- R3: The enable register of group g (offset 0x828 + 12*g) and its mask register (0x82C + 12*g) read back exactly what was written.
- R4: An accepted inbound write whose 64-bit address equals the doorbell address, with data value v below 32*GROUPS and vector v enabled, sets bit v%32 of the pending register of group v/32 (offset 0x830 + 12*g). The bit reads as set from the next clock edge.
- R5: An inbound write whose address differs from the doorbell address in either word sets no pending bit.
- R6: An inbound write whose data selects a disabled vector, or whose data value is 32*GROUPS or more (upper data bits nonzero included), is dropped and sets no pending bit.
- R7: Writing a pending register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R8: A mask bit does not stop its pending bit from latching. It only keeps that bit out of `irq_out`.
- R9: `irq_out` is registered. It is high one cycle after any group holds a bit that is set in pending and clear in mask, and low one cycle after no such bit exists.
- R10: Offsets outside the doorbell and implemented group registers read zero, and writes to them have no effect.
- R11: If an inbound write sets a bit in the same cycle that software clears that bit, the bit ends set.
- R12: `in_ready` is always high. The inbound port accepts one write per cycle whenever `in_valid` is high and never applies back-pressure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| in_valid | input | 1 | Inbound MSI write valid |
| in_ready | output | 1 | Inbound port ready, always 1 |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data (vector number) |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
The checks assume that register writes use word-aligned offsets and that `in_addr` and `in_data` are stable and known whenever `in_valid` is high. Inbound and register traffic may coincide only at the pending register of group 0, where the set-versus-clear order is checked. The stimulus changes inputs only on falling edges. It holds `in_valid` for exactly one cycle per write and keeps all other register strobes idle while an inbound write that the bench expects to be dropped is in flight.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int VEC_PER_GRP = 32;
  localparam int GRP_STRIDE  = 12;
  localparam logic [11:0] OFF_TGT_LO = 12'h820;
  localparam logic [11:0] OFF_TGT_HI = 12'h824;
  localparam logic [11:0] OFF_GRP0   = 12'h828;
endpackage

// File: rtl/msi_target_match.sv
module msi_target_match
  import msi_cap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic [63:0] in_addr,
  output logic        addr_hit,
  output logic [63:0] target,
  output logic        rd_hit,
  output logic [31:0] rd_data
);
  logic [31:0] tgt_lo, tgt_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_lo <= '0;
      tgt_hi <= '0;
    end else if (reg_we) begin
      if (reg_addr == OFF_TGT_LO) tgt_lo <= reg_wdata;
      if (reg_addr == OFF_TGT_HI) tgt_hi <= reg_wdata;
    end
  end

  assign target   = {tgt_hi, tgt_lo};
  assign addr_hit = (in_addr == target);

  always_comb begin
    rd_hit  = 1'b1;
    rd_data = '0;
    if (reg_addr == OFF_TGT_LO)      rd_data = tgt_lo;
    else if (reg_addr == OFF_TGT_HI) rd_data = tgt_hi;
    else                             rd_hit  = 1'b0;
  end
endmodule

// File: rtl/msi_vec_group.sv
module msi_vec_group
  import msi_cap_pkg::*;
#(
  parameter int GROUP_IDX = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        cap_sel,
  input  logic [4:0]  cap_bit,
  output logic [31:0] enable,
  output logic [31:0] mask,
  output logic [31:0] status,
  output logic        rd_hit,
  output logic [31:0] rd_data
);
  localparam logic [11:0] EN_OFF = 12'(int'(OFF_GRP0) + GROUP_IDX * GRP_STRIDE);
  localparam logic [11:0] MK_OFF = EN_OFF + 12'd4;
  localparam logic [11:0] ST_OFF = EN_OFF + 12'd8;

  logic [31:0] set_bits, clr_bits;

  assign set_bits = cap_sel ? (enable & (32'd1 << cap_bit)) : '0;
  assign clr_bits = (reg_we && reg_addr == ST_OFF) ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= '0;
      mask   <= '0;
      status <= '0;
    end else begin
      if (reg_we && reg_addr == EN_OFF) enable <= reg_wdata;
      if (reg_we && reg_addr == MK_OFF) mask   <= reg_wdata;
      status <= (status & ~clr_bits) | set_bits;
    end
  end

  always_comb begin
    rd_hit  = 1'b1;
    rd_data = '0;
    if (reg_addr == EN_OFF)      rd_data = enable;
    else if (reg_addr == MK_OFF) rd_data = mask;
    else if (reg_addr == ST_OFF) rd_data = status;
    else                         rd_hit  = 1'b0;
  end
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_cap_pkg::*;
#(
  parameter int GROUPS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_addr,
  input  logic [31:0] in_data,
  output logic        irq_out
);
  localparam int NVEC = GROUPS * VEC_PER_GRP;
  localparam int GW   = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic        addr_hit, tgt_rd_hit;
  logic [63:0] target;
  logic [31:0] tgt_rd_data;
  logic        accept;
  logic [GW-1:0] grp_idx;

  logic [GROUPS*32-1:0] enable_all, mask_all, status_all;
  logic [GROUPS-1:0]    grp_rd_hit;
  logic [31:0]          grp_rd_data [GROUPS];
  logic                 irq_q;

  assign in_ready = 1'b1;
  assign accept   = in_valid && addr_hit && (in_data < 32'(NVEC));
  assign grp_idx  = in_data[5 +: GW];

  msi_target_match u_match (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .in_addr(in_addr), .addr_hit(addr_hit),
    .target(target), .rd_hit(tgt_rd_hit), .rd_data(tgt_rd_data)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    msi_vec_group #(.GROUP_IDX(g)) u_grp (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata),
      .cap_sel(accept && (int'(grp_idx) == g)),
      .cap_bit(in_data[4:0]),
      .enable(enable_all[g*32 +: 32]),
      .mask(mask_all[g*32 +: 32]),
      .status(status_all[g*32 +: 32]),
      .rd_hit(grp_rd_hit[g]),
      .rd_data(grp_rd_data[g])
    );
  end

  always_comb begin
    reg_rdata = tgt_rd_hit ? tgt_rd_data : '0;
    for (int g = 0; g < GROUPS; g++)
      if (grp_rd_hit[g]) reg_rdata = grp_rd_data[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_all & ~mask_all);
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk #(
  parameter int GROUPS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [11:0]          reg_addr,
  input logic [31:0]          reg_wdata,
  input logic                 in_valid,
  input logic [63:0]          in_addr,
  input logic [31:0]          in_data,
  input logic                 irq_out,
  input logic [63:0]          target,
  input logic [GROUPS*32-1:0] enable_all,
  input logic [GROUPS*32-1:0] mask_all,
  input logic [GROUPS*32-1:0] status_all
);
  localparam int NVEC = GROUPS * 32;
  localparam int VW   = $clog2(NVEC);

  logic good_cap;
  assign good_cap = in_valid && (in_addr == target) && (in_data < 32'(NVEC))
                    && enable_all[in_data[VW-1:0]];

  // R4
  capture_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_cap |=> status_all[$past(in_data[VW-1:0])]);

  // R5
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_addr == target) |=> ((status_all & ~$past(status_all)) == '0));

  // R7
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 12'h830 && !(good_cap && in_data < 32'd32))
    |=> ((status_all[31:0] & $past(reg_wdata)) == 32'd0));

  // R11
  set_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 12'h830 && good_cap && in_data < 32'd32)
    |=> status_all[$past(in_data[4:0])]);

  // R3
  enable_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 12'h828) |=> (enable_all[31:0] == $past(reg_wdata)));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(|(status_all & ~mask_all)));
endmodule

bind msi_capture_ctrl msi_capture_chk #(.GROUPS(GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .in_valid(in_valid), .in_addr(in_addr),
  .in_data(in_data), .irq_out(irq_out), .target(target),
  .enable_all(enable_all), .mask_all(mask_all), .status_all(status_all)
);

// File: tb/msi_capture_ctrl_test.sv
`timescale 1ns/1ps
module msi_capture_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [63:0] TGT = 64'h0000_00F0_DEAD_B000;

  always #4 clk = ~clk;

  msi_capture_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data), .irq_out(irq_out)
  );

  // vector table: inbound data, pending-register offset to read, expected value
  typedef struct packed {
    logic [31:0] data;
    logic [11:0] off;
    logic [31:0] exp;
  } vec_t;
  localparam int NROWS = 8;
  localparam vec_t TABLE [NROWS] = '{
    '{32'd0,         12'h830, 32'h0000_0001},
    '{32'd31,        12'h830, 32'h8000_0000},
    '{32'd32,        12'h83C, 32'h0000_0001},
    '{32'd69,        12'h848, 32'h0000_0020},
    '{32'd100,       12'h854, 32'h0000_0000},
    '{32'd255,       12'h884, 32'h8000_0000},
    '{32'd256,       12'h830, 32'h0000_0000},
    '{32'h1000_0005, 12'h830, 32'h0000_0000}
  };
  localparam string TAGS [NROWS] = '{"R4", "R4", "R4", "R4", "R6", "R4", "R6", "R6"};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(logic [63:0] a, logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(12'h820, v); check("R1", v, 32'h0);
    rd(12'h828, v); check("R1", v, 32'h0);
    rd(12'h830, v); check("R1", v, 32'h0);
    check("R1", {31'd0, irq_out}, 32'd0);
    check("R12", {31'd0, in_ready}, 32'd1);

    // R2 doorbell address
    wr(12'h820, TGT[31:0]); wr(12'h824, TGT[63:32]);
    rd(12'h820, v); check("R2", v, TGT[31:0]);
    rd(12'h824, v); check("R2", v, TGT[63:32]);

    // R3 enable and mask readback
    wr(12'h828, 32'hA5A5_0F0F); rd(12'h828, v); check("R3", v, 32'hA5A5_0F0F);
    wr(12'h82C, 32'h1234_5678); rd(12'h82C, v); check("R3", v, 32'h1234_5678);
    wr(12'h82C, 32'h0);

    // R10 unimplemented offset
    wr(12'h888, 32'hFFFF_FFFF); rd(12'h888, v); check("R10", v, 32'h0);

    // enable all groups except group 3, mask everything so irq stays out
    for (int g = 0; g < 8; g++) begin
      wr(12'(12'h828 + g * 12), (g == 3) ? 32'h0 : 32'hFFFF_FFFF);
      wr(12'(12'h82C + g * 12), 32'hFFFF_FFFF);
    end

    // table walk: R4 and R6
    for (int i = 0; i < NROWS; i++) begin
      send(TGT, TABLE[i].data);
      rd(TABLE[i].off, v); check(TAGS[i], v, TABLE[i].exp);
      wr(TABLE[i].off, 32'hFFFF_FFFF);
    end

    // R5 address mismatch in each word
    send(TGT ^ 64'h1_0000_0000, 32'd3);
    send(TGT ^ 64'h4, 32'd3);
    rd(12'h830, v); check("R5", v, 32'h0);

    // R7 write-one-to-clear
    send(TGT, 32'd1); send(TGT, 32'd2);
    wr(12'h830, 32'h2); rd(12'h830, v); check("R7", v, 32'h4);
    wr(12'h830, 32'h0); rd(12'h830, v); check("R7", v, 32'h4);

    // R8: bit 2 masked, pending but no interrupt
    @(negedge clk); @(negedge clk);
    check("R8", {31'd0, irq_out}, 32'd0);
    // R9: unmask, irq one cycle later
    wr(12'h82C, 32'hFFFF_FFFB);
    @(negedge clk);
    check("R9", {31'd0, irq_out}, 32'd1);
    wr(12'h830, 32'h4);
    @(negedge clk);
    check("R9", {31'd0, irq_out}, 32'd0);

    // R11 set and clear of the same bit in one cycle
    send(TGT, 32'd1);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'h830; reg_wdata = 32'h2;
    in_valid = 1'b1; in_addr = TGT; in_data = 32'd1;
    @(negedge clk);
    reg_we = 1'b0; in_valid = 1'b0;
    rd(12'h830, v); check("R11", v, 32'h2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule